// File: doc/BRIEF.md
# Length-Selectable Up/Down Counter with Compare and PWM

This block is a general-purpose timer and event counter. A count register steps by one each time the selected count source gives an enable. It counts up or down, and it can be limited to an active length of 10, 8, 6 or 4 bits. It wraps within that length. The count source is one of eight prescaler taps, supplied as a bus of one-cycle enables, or one of two external event inputs, or a free-running half-rate enable taken from the block clock.

Software-side logic programs the block through three write strobes: one for control (run, direction, length, compare mode and source), one for the reload value and one for the compare value. A compare-match request and a reached-zero request are produced as one-cycle pulses. A pulse-width output is derived from the same count and compare value.

Top module: `updown_pwm_timer`

## Requirements
- R1: After reset the count is 0, both request outputs are low and the PWM output is low.
- R2: While running and counting up, each enable from the selected source adds one to the count, and the count goes from the all-ones value of the active length to 0.
- R3: While running and counting down, each enable subtracts one, and the count goes from 0 to the all-ones value of the active length.
- R4: The length code selects the active length: 0 selects 10 bits, 1 selects 8, 2 selects 6 and 3 selects 4. Every count step leaves all bits above the active length at 0, even when the previous value had them set.
- R5: The source code selects the count source. Codes 0 to 7 select the prescaler tap with that index, 8 selects event input A, 9 selects event input B and 10 selects the half-rate enable, which gives exactly one step in any two consecutive cycles. Codes 11 to 15 select no source. Enables from sources that are not selected have no effect on the count.
- R6: An event input passes through two synchronizing flops and counts once per rising edge, however long it stays high. The count shows the step after the third clock edge, counting the edge that first samples the input high as the first.
- R7: With the counter stopped, a reload write appears on the count in the cycle after the strobe, and the count then holds still.
- R8: With the counter running, a reload write leaves the count unchanged. The next enable from the selected source loads the reload value in place of a count step.
- R9: The compare request is high for exactly the one cycle in which the count has stepped onto a matching value. In full mode (compare-mode bit 1) all 10 bits must match. In limited mode (bit 0) only the bits within the active length are compared.
- R10: The zero request is high for the one cycle in which a count step has made the count 0. A reload to 0 does not raise it.
- R11: One cycle after a step that wraps, or after a reload takes effect, the PWM output goes high. One cycle after a step onto a compare match it goes low.
- R12: When the compare value's bits within the active length are all 0, the PWM output is held low. When they are all 1, it is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_en | input | 8 | One-cycle enables from the prescaler taps |
| ev_a | input | 1 | External event input A (asynchronous) |
| ev_b | input | 1 | External event input B (asynchronous) |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_run | input | 1 | Run bit for the control write |
| ctrl_up | input | 1 | Direction bit for the control write, 1 counts up |
| ctrl_len | input | 2 | Length code for the control write |
| ctrl_fullcmp | input | 1 | Compare mode for the control write, 1 compares all bits |
| ctrl_src | input | 4 | Source code for the control write |
| load_wr | input | 1 | Reload value write strobe |
| load_data | input | 10 | Reload value |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_data | input | 10 | Compare value |
| count | output | 10 | Current count |
| irq_cmp | output | 1 | Compare-match request pulse |
| irq_zero | output | 1 | Reached-zero request pulse |
| pwm_out | output | 1 | Pulse-width output |

## Verification
The count and both request pulses are due in the cycle right after the clock edge that captures a tap enable or a stopped-mode reload. A PWM edge caused by a step or reload is due one cycle later, and the forced PWM levels follow a compare write one cycle after its strobe. An event-input step is due three edges after the input is first sampled high. Each driver action queues its expected values stamped with the exact falling edge at which they are due, so the monitor compares each output only in the cycle the requirement names. It also checks the cycles just before and just after a pulse, to pin down that the pulse lasts one cycle.

// File: rtl/uctr_pkg.sv
`timescale 1ns/1ps
package uctr_pkg;
    localparam int CNT_W    = 10;
    localparam int N_TAPS   = 8;
    localparam int N_SRC    = N_TAPS + 3;
    localparam int SRC_W    = $clog2(N_SRC);
    localparam int SRC_EV_A = N_TAPS;
    localparam int SRC_EV_B = N_TAPS + 1;
    localparam int SRC_HALF = N_TAPS + 2;
    localparam int N_EV     = 2;
    localparam int SYNC_D   = 3;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        LEN_FULL = 2'd0,
        LEN_M2   = 2'd1,
        LEN_M4   = 2'd2,
        LEN_M6   = 2'd3
    } len_e;

    typedef struct packed {
        logic             run;
        logic             up;
        len_e             len;
        logic             full_cmp;
        logic [SRC_W-1:0] src;
    } ctrl_t;

    typedef struct packed {
        logic stepped;
        logic wrapped;
        logic loaded;
    } evt_t;

    function automatic cnt_t len_mask(len_e l);
        int   bits;
        cnt_t m;
        bits = CNT_W - 2 * int'(l);
        m    = '0;
        for (int i = 0; i < CNT_W; i++) begin
            m[i] = (i < bits);
        end
        return m;
    endfunction

    function automatic cnt_t step_value(cnt_t c, logic up, cnt_t mask);
        cnt_t n;
        n = up ? (c + cnt_t'(1)) : (c - cnt_t'(1));
        return n & mask;
    endfunction

    function automatic logic wraps(cnt_t c, logic up, cnt_t mask);
        return up ? ((c & mask) == mask) : ((c & mask) == '0);
    endfunction
endpackage

// File: rtl/uctr_src_select.sv
`timescale 1ns/1ps
module uctr_src_select
    import uctr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TAPS-1:0] tap_en,
    input  logic [N_EV-1:0]   ev_in,
    input  logic [SRC_W-1:0]  src,
    output logic              src_tick
);
    logic [N_EV-1:0] ev_edge;
    logic            half_q;

    for (genvar g = 0; g < N_EV; g++) begin : g_ev
        logic [SYNC_D-1:0] sh_q;
        always_ff @(posedge clk) begin
            if (rst) sh_q <= '0;
            else     sh_q <= {sh_q[SYNC_D-2:0], ev_in[g]};
        end
        assign ev_edge[g] = sh_q[SYNC_D-2] & ~sh_q[SYNC_D-1];
    end

    always_ff @(posedge clk) begin
        if (rst) half_q <= 1'b0;
        else     half_q <= ~half_q;
    end

    always_comb begin
        src_tick = 1'b0;
        for (int i = 0; i < N_TAPS; i++) begin
            if (src == SRC_W'(i)) src_tick = tap_en[i];
        end
        if (src == SRC_W'(SRC_EV_A)) src_tick = ev_edge[0];
        if (src == SRC_W'(SRC_EV_B)) src_tick = ev_edge[1];
        if (src == SRC_W'(SRC_HALF)) src_tick = half_q;
    end
endmodule

// File: rtl/uctr_core.sv
`timescale 1ns/1ps
module uctr_core
    import uctr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic run,
    input  logic up,
    input  cnt_t mask,
    input  logic load_wr,
    input  cnt_t load_data,
    output cnt_t cnt_q,
    output evt_t evt_q,
    output logic pend_q
);
    cnt_t reload_q;
    logic apply;

    assign apply = pend_q & (tick | ~run);

    always_ff @(posedge clk) begin
        if (rst)          reload_q <= '0;
        else if (load_wr) reload_q <= load_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            evt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            evt_q <= '0;
            if (load_wr && !run) begin
                cnt_q        <= load_data;
                evt_q.loaded <= 1'b1;
                pend_q       <= 1'b0;
            end else begin
                if (apply) begin
                    cnt_q        <= reload_q;
                    evt_q.loaded <= 1'b1;
                end else if (tick) begin
                    cnt_q         <= step_value(cnt_q, up, mask);
                    evt_q.stepped <= 1'b1;
                    evt_q.wrapped <= wraps(cnt_q, up, mask);
                end
                if (load_wr)    pend_q <= 1'b1;
                else if (apply) pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uctr_pwm_irq.sv
`timescale 1ns/1ps
module uctr_pwm_irq
    import uctr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cnt_t cnt,
    input  cnt_t cmp,
    input  cnt_t mask,
    input  logic full_cmp,
    input  evt_t evt,
    output logic irq_cmp,
    output logic irq_zero,
    output logic pwm_out
);
    cnt_t cnt_f;
    cnt_t cmp_f;
    logic match;
    logic pwm_q;

    assign cnt_f = cnt & mask;
    assign cmp_f = cmp & mask;
    assign match = full_cmp ? (cnt == cmp) : (cnt_f == cmp_f);

    assign irq_cmp  = evt.stepped & match;
    assign irq_zero = evt.stepped & (cnt_f == '0);

    always_ff @(posedge clk) begin
        if (rst)                            pwm_q <= 1'b0;
        else if (evt.stepped && match)      pwm_q <= 1'b0;
        else if (evt.wrapped || evt.loaded) pwm_q <= 1'b1;
    end

    always_comb begin
        if (cmp_f == '0)        pwm_out = 1'b0;
        else if (cmp_f == mask) pwm_out = 1'b1;
        else                    pwm_out = pwm_q;
    end
endmodule

// File: rtl/updown_pwm_timer.sv
`timescale 1ns/1ps
module updown_pwm_timer
    import uctr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TAPS-1:0] tap_en,
    input  logic              ev_a,
    input  logic              ev_b,
    input  logic              ctrl_wr,
    input  logic              ctrl_run,
    input  logic              ctrl_up,
    input  logic [1:0]        ctrl_len,
    input  logic              ctrl_fullcmp,
    input  logic [SRC_W-1:0]  ctrl_src,
    input  logic              load_wr,
    input  logic [CNT_W-1:0]  load_data,
    input  logic              cmp_wr,
    input  logic [CNT_W-1:0]  cmp_data,
    output logic [CNT_W-1:0]  count,
    output logic              irq_cmp,
    output logic              irq_zero,
    output logic              pwm_out
);
    ctrl_t ctrl_q;
    cnt_t  cmp_q;
    cnt_t  mask;
    cnt_t  cnt_q;
    evt_t  evt_q;
    logic  src_tick;
    logic  tick;
    logic  load_pend;
    logic  run_s;
    logic  stepped_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.run      <= ctrl_run;
            ctrl_q.up       <= ctrl_up;
            ctrl_q.len      <= len_e'(ctrl_len);
            ctrl_q.full_cmp <= ctrl_fullcmp;
            ctrl_q.src      <= ctrl_src;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         cmp_q <= '0;
        else if (cmp_wr) cmp_q <= cmp_data;
    end

    assign mask      = len_mask(ctrl_q.len);
    assign tick      = src_tick & ctrl_q.run;
    assign run_s     = ctrl_q.run;
    assign stepped_s = evt_q.stepped;

    uctr_src_select u_src (
        .clk      (clk),
        .rst      (rst),
        .tap_en   (tap_en),
        .ev_in    ({ev_b, ev_a}),
        .src      (ctrl_q.src),
        .src_tick (src_tick)
    );

    uctr_core u_core (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .run       (ctrl_q.run),
        .up        (ctrl_q.up),
        .mask      (mask),
        .load_wr   (load_wr),
        .load_data (load_data),
        .cnt_q     (cnt_q),
        .evt_q     (evt_q),
        .pend_q    (load_pend)
    );

    uctr_pwm_irq u_out (
        .clk      (clk),
        .rst      (rst),
        .cnt      (cnt_q),
        .cmp      (cmp_q),
        .mask     (mask),
        .full_cmp (ctrl_q.full_cmp),
        .evt      (evt_q),
        .irq_cmp  (irq_cmp),
        .irq_zero (irq_zero),
        .pwm_out  (pwm_out)
    );

    assign count = cnt_q;
endmodule

// File: rtl/uctr_checker.sv
`timescale 1ns/1ps
module uctr_checker
    import uctr_pkg::*;
(
    input logic clk,
    input logic rst,
    input cnt_t count,
    input logic irq_cmp,
    input logic irq_zero,
    input logic pwm_out,
    input logic run,
    input logic load_wr,
    input logic pend,
    input logic stepped,
    input cnt_t mask,
    input cnt_t cmp
);
    // R10
    zero_irq_value_chk: assert property (@(posedge clk) disable iff (rst)
        irq_zero |-> (count == '0));

    // R9
    cmp_irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq_cmp |=> !irq_cmp);

    // R7
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !load_wr && !pend) |=> $stable(count));

    // R4
    step_in_length_chk: assert property (@(posedge clk) disable iff (rst)
        (stepped && $stable(mask)) |-> ((count & ~mask) == '0));

    // R11
    pwm_fall_after_match_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(pwm_out) && $stable(cmp) && $stable(mask)) |-> $past(irq_cmp));
endmodule

bind updown_pwm_timer uctr_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .count    (count),
    .irq_cmp  (irq_cmp),
    .irq_zero (irq_zero),
    .pwm_out  (pwm_out),
    .run      (run_s),
    .load_wr  (load_wr),
    .pend     (load_pend),
    .stepped  (stepped_s),
    .mask     (mask),
    .cmp      (cmp_q)
);

// File: tb/updown_pwm_timer_test.sv
`timescale 1ns/1ps
module updown_pwm_timer_test;
    import uctr_pkg::*;

    localparam int S_CNT = 0;
    localparam int S_CMP = 1;
    localparam int S_ZER = 2;
    localparam int S_PWM = 3;

    typedef struct {
        int    due;
        int    sig;
        int    val;
        string req;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_TAPS-1:0] tap_en = '0;
    logic              ev_a = 1'b0;
    logic              ev_b = 1'b0;
    logic              ctrl_wr = 1'b0;
    logic              ctrl_run = 1'b0;
    logic              ctrl_up = 1'b0;
    logic [1:0]        ctrl_len = '0;
    logic              ctrl_fullcmp = 1'b0;
    logic [SRC_W-1:0]  ctrl_src = '0;
    logic              load_wr = 1'b0;
    logic [CNT_W-1:0]  load_data = '0;
    logic              cmp_wr = 1'b0;
    logic [CNT_W-1:0]  cmp_data = '0;
    logic [CNT_W-1:0]  count;
    logic              irq_cmp;
    logic              irq_zero;
    logic              pwm_out;

    int    cyc = 0;
    int    n_checks = 0;
    int    n_fail = 0;
    item_t q[$];

    updown_pwm_timer uut (
        .clk(clk), .rst(rst), .tap_en(tap_en), .ev_a(ev_a), .ev_b(ev_b),
        .ctrl_wr(ctrl_wr), .ctrl_run(ctrl_run), .ctrl_up(ctrl_up),
        .ctrl_len(ctrl_len), .ctrl_fullcmp(ctrl_fullcmp), .ctrl_src(ctrl_src),
        .load_wr(load_wr), .load_data(load_data), .cmp_wr(cmp_wr),
        .cmp_data(cmp_data), .count(count), .irq_cmp(irq_cmp),
        .irq_zero(irq_zero), .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;

    function automatic int read_sig(int s);
        case (s)
            S_CNT:   return int'(count);
            S_CMP:   return int'(irq_cmp);
            S_ZER:   return int'(irq_zero);
            default: return int'(pwm_out);
        endcase
    endfunction

    // monitor: pops every item due at this falling edge
    always @(negedge clk) begin
        int i;
        int act;
        cyc++;
        i = 0;
        while (i < q.size()) begin
            if (q[i].due == cyc) begin
                act = read_sig(q[i].sig);
                n_checks++;
                if (act != q[i].val) begin
                    n_fail++;
                    $display("FAIL %s sig%0d cycle %0d: actual=%0d expected=%0d",
                             q[i].req, q[i].sig, cyc, act, q[i].val);
                end
                q.delete(i);
            end else begin
                i++;
            end
        end
    end

    task automatic expect_at(int d, int sig, int val, string req);
        item_t it;
        it.due = cyc + d;
        it.sig = sig;
        it.val = val;
        it.req = req;
        q.push_back(it);
    endtask

    task automatic cyc_wait(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_ctrl(logic run, logic up, logic [1:0] len, logic full, int src);
        ctrl_run = run; ctrl_up = up; ctrl_len = len;
        ctrl_fullcmp = full; ctrl_src = SRC_W'(src);
        ctrl_wr = 1'b1;
        cyc_wait(1);
        ctrl_wr = 1'b0;
    endtask

    task automatic do_load(int v);
        load_data = CNT_W'(v);
        load_wr = 1'b1;
        cyc_wait(1);
        load_wr = 1'b0;
    endtask

    task automatic do_cmp(int v);
        cmp_data = CNT_W'(v);
        cmp_wr = 1'b1;
        cyc_wait(1);
        cmp_wr = 1'b0;
    endtask

    task automatic tap(int idx);
        tap_en[idx] = 1'b1;
        cyc_wait(1);
        tap_en = '0;
    endtask

    initial begin
        cyc_wait(3);
        rst = 1'b0;
        // R1 reset state
        expect_at(1, S_CNT, 0, "R1");
        expect_at(1, S_CMP, 0, "R1");
        expect_at(1, S_ZER, 0, "R1");
        expect_at(1, S_PWM, 0, "R1");
        cyc_wait(2);

        // 4-bit up counting, compare 5
        do_cmp(5);
        set_ctrl(1'b0, 1'b1, 2'd3, 1'b0, 0);
        do_load(13);
        expect_at(1, S_CNT, 13, "R7");
        expect_at(2, S_PWM, 1, "R11");
        cyc_wait(3);
        expect_at(1, S_CNT, 13, "R7");
        set_ctrl(1'b1, 1'b1, 2'd3, 1'b0, 0);
        tap(0);
        tap(0);
        expect_at(1, S_CNT, 15, "R2");
        tap(0);
        expect_at(1, S_CNT, 0, "R2");
        expect_at(1, S_ZER, 1, "R10");
        expect_at(1, S_CMP, 0, "R9");
        expect_at(2, S_ZER, 0, "R10");
        for (int k = 1; k <= 4; k++) tap(0);
        tap(0);
        expect_at(1, S_CNT, 5, "R2");
        expect_at(1, S_CMP, 1, "R9");
        expect_at(1, S_PWM, 1, "R11");
        expect_at(2, S_CMP, 0, "R9");
        expect_at(2, S_PWM, 0, "R11");
        for (int k = 6; k <= 15; k++) tap(0);
        tap(0);
        expect_at(1, S_PWM, 0, "R11");
        expect_at(2, S_PWM, 1, "R11");
        cyc_wait(2);

        // limited versus full compare
        do_cmp(12'h35);
        for (int k = 1; k <= 4; k++) tap(0);
        tap(0);
        expect_at(1, S_CMP, 1, "R9");
        cyc_wait(2);
        set_ctrl(1'b1, 1'b1, 2'd3, 1'b1, 0);
        for (int k = 0; k < 15; k++) tap(0);
        tap(0);
        expect_at(1, S_CNT, 5, "R9");
        expect_at(1, S_CMP, 0, "R9");
        cyc_wait(2);

        // upper bits cleared by a step
        set_ctrl(1'b0, 1'b1, 2'd3, 1'b0, 0);
        do_load(12'h3F5);
        expect_at(1, S_CNT, 12'h3F5, "R7");
        cyc_wait(1);
        set_ctrl(1'b1, 1'b1, 2'd3, 1'b0, 0);
        tap(0);
        expect_at(1, S_CNT, 6, "R4");
        cyc_wait(1);
        set_ctrl(1'b0, 1'b1, 2'd2, 1'b0, 0);
        do_load(12'h3F);
        set_ctrl(1'b1, 1'b1, 2'd2, 1'b0, 0);
        tap(0);
        expect_at(1, S_CNT, 0, "R4");
        expect_at(1, S_ZER, 1, "R4");
        cyc_wait(2);

        // 8-bit down counting
        set_ctrl(1'b0, 1'b0, 2'd1, 1'b0, 0);
        do_load(2);
        expect_at(1, S_CNT, 2, "R7");
        set_ctrl(1'b1, 1'b0, 2'd1, 1'b0, 0);
        tap(0);
        expect_at(1, S_CNT, 1, "R3");
        tap(0);
        expect_at(1, S_CNT, 0, "R3");
        expect_at(1, S_ZER, 1, "R10");
        tap(0);
        expect_at(1, S_CNT, 255, "R3");
        expect_at(1, S_ZER, 0, "R10");
        expect_at(2, S_PWM, 1, "R11");
        cyc_wait(2);

        // reload while running
        set_ctrl(1'b1, 1'b1, 2'd0, 1'b0, 0);
        do_load(100);
        expect_at(1, S_CNT, 255, "R8");
        cyc_wait(3);
        expect_at(1, S_CNT, 255, "R8");
        tap(0);
        expect_at(1, S_CNT, 100, "R8");
        expect_at(1, S_ZER, 0, "R8");
        tap(0);
        expect_at(1, S_CNT, 101, "R8");
        set_ctrl(1'b0, 1'b1, 2'd0, 1'b0, 0);
        do_load(0);
        expect_at(1, S_CNT, 0, "R7");
        expect_at(1, S_ZER, 0, "R10");
        cyc_wait(2);

        // source selection
        set_ctrl(1'b1, 1'b1, 2'd0, 1'b0, 0);
        tap(1);
        expect_at(1, S_CNT, 0, "R5");
        set_ctrl(1'b1, 1'b1, 2'd0, 1'b0, 3);
        tap(3);
        expect_at(1, S_CNT, 1, "R5");
        set_ctrl(1'b1, 1'b1, 2'd0, 1'b0, SRC_EV_A);
        ev_a = 1'b1;
        expect_at(3, S_CNT, 1, "R6");
        expect_at(4, S_CNT, 2, "R6");
        cyc_wait(10);
        expect_at(1, S_CNT, 2, "R6");
        ev_a = 1'b0;
        cyc_wait(5);
        ev_b = 1'b1;
        cyc_wait(5);
        ev_b = 1'b0;
        cyc_wait(5);
        expect_at(1, S_CNT, 2, "R5");
        set_ctrl(1'b1, 1'b1, 2'd0, 1'b0, SRC_EV_B);
        ev_b = 1'b1;
        cyc_wait(6);
        expect_at(1, S_CNT, 3, "R5");
        ev_b = 1'b0;
        cyc_wait(4);

        // half-rate source
        set_ctrl(1'b0, 1'b1, 2'd0, 1'b0, SRC_HALF);
        do_load(0);
        set_ctrl(1'b1, 1'b1, 2'd0, 1'b0, SRC_HALF);
        cyc_wait(9);
        set_ctrl(1'b0, 1'b1, 2'd0, 1'b0, SRC_HALF);
        expect_at(1, S_CNT, 5, "R5");
        cyc_wait(3);
        expect_at(1, S_CNT, 5, "R5");
        set_ctrl(1'b1, 1'b1, 2'd0, 1'b0, 11);
        tap_en = '1;
        cyc_wait(3);
        tap_en = '0;
        expect_at(1, S_CNT, 5, "R5");
        cyc_wait(2);

        // forced PWM levels
        set_ctrl(1'b1, 1'b1, 2'd3, 1'b0, 0);
        do_cmp(12'h10);
        expect_at(1, S_PWM, 0, "R12");
        for (int k = 0; k < 3; k++) tap(0);
        expect_at(1, S_PWM, 0, "R12");
        cyc_wait(2);
        do_cmp(12'h0F);
        expect_at(1, S_PWM, 1, "R12");
        for (int k = 0; k < 12; k++) tap(0);
        expect_at(1, S_PWM, 1, "R12");
        expect_at(2, S_PWM, 1, "R12");
        cyc_wait(4);

        if (q.size() != 0) begin
            n_fail += q.size();
            $display("FAIL all: %0d expectations never reached, actual=%0d expected=0",
                     q.size(), q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule